// File: doc/BRIEF.md
# Daisy-Chainable DAC Serial Command Interface

This block is the digital front end of a serially programmed digital-to-analog converter. A host shifts frames in on a serial data line, one bit per rising edge of a serial clock, while an active-low chip-select/load line is held low. When that line returns high, shifting stops and the block decodes the command in the frame. The command can set the output-range mode, load a staged input register, or copy that register into the DAC code register that drives the converter. The block outputs only the DAC code and the four range-select bits.

The serial clock, chip-select and data inputs are brought into the system clock domain by a short synchronizer, and their edges are detected there. All of the shifting state sits in a 32-bit chain register. Its top bit is presented on a serial output, so several devices can share the clock and chip-select lines and be chained output-to-input. The command and data are always read from fixed positions near the bottom of the chain register. As a result, a 24-bit standalone frame and a 32-bit chained frame (whose first eight bits carry no meaning) decode identically, and no bit counter is needed.

A power-on reset and a separate asynchronous clear both zero the registers. They differ in one point: power-on sets the range to the 5 V unipolar code, while the clear leaves the range at zero until the host reprograms it. A parameter selects 12-, 14- or 16-bit resolution. The lowest bits of the 16-bit data word are dropped when the resolution is narrower.

Top module: `dac_serial_front`

## Requirements
- R1: After power-on reset (rstN low), dacCode is 0, rangeMode is 4'b1000 and sdo is 0.
- R2: A rising sck edge shifts sdi into the chain register only while csLd is low. sck edges while csLd is high leave the chain register, and therefore sdo, unchanged.
- R3: On the rising edge of csLd, the command is read from chain bits [23:20] and the data word from chain bits [15:0]. A 24-bit frame (4 command bits, 4 ignored bits, 16 data bits, MSB first) therefore acts exactly like a 32-bit frame that has the same 24 bits preceded by 8 ignored bits.
- R4: Command codes 4'b1000 to 4'b1101 set rangeMode to the command code and load the input register from the data word. dacCode does not change.
- R5: Command 4'b0011 loads the input register from the data word and also sets dacCode to that data in the same execution.
- R6: Command 4'b0010 loads the input register only. Command 4'b0001 copies the input register to dacCode and ignores the frame's data.
- R7: Codes 4'b0000, 4'b0100 to 4'b0111, 4'b1110 and 4'b1111 change neither dacCode, rangeMode nor the input register.
- R8: sdo equals chain bit 31, so after N ≥ 32 shifting edges sdo holds the bit shifted in at edge N-31. The next device in the chain therefore receives each bit 32 edges after this one did.
- R9: Driving clrN low zeroes the chain register, the input register, dacCode and rangeMode (4'b0000). A 4'b0001 command issued directly after a clear leaves dacCode at 0.
- R10: With RES less than 16, dacCode takes data bits [15:16-RES] and the lower 16-RES bits are ignored. For example, with RES=12, data 16'hABCD gives 12'hABC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| clrN | input | 1 | Asynchronous active-low clear |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| csLd | input | 1 | Active-low chip select; its rising edge executes the frame |
| sdi | input | 1 | Serial data input, MSB first |
| sdo | output | 1 | Daisy-chain output, chain register bit 31 |
| dacCode | output | RES | Code delivered to the converter |
| rangeMode | output | 4 | Output-range select bits |

## Verification
A corrupted chain register shows on sdo once the bad bit reaches bit 31, which can take up to 32 edges. The same corruption shows at once in the next executed command, as a wrong dacCode or rangeMode a few system clocks after csLd rises. A stale or wrongly loaded input register stays hidden until a later 4'b0001 command exposes it. For that reason the stimulus mixes load-only and no-op frames with later update frames. A wrong clear value for the range shows directly on rangeMode, and the update that follows a clear shows whether the input register was really zeroed.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;
  localparam int CHAIN_W  = 32;
  localparam int WORD_W   = 16;
  localparam int CMD_MSB  = 23;
  localparam int CMD_W    = 4;

  typedef struct packed {
    logic shiftEn;
    logic loadMode;
    logic loadInput;
    logic updateDac;
  } strobe_t;

  localparam logic [CMD_W-1:0] CMD_UPDATE   = 4'b0001;
  localparam logic [CMD_W-1:0] CMD_LOAD     = 4'b0010;
  localparam logic [CMD_W-1:0] CMD_LOAD_UPD = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_RANGE_LO = 4'b1000;
  localparam logic [CMD_W-1:0] CMD_RANGE_HI = 4'b1101;
  localparam logic [CMD_W-1:0] MODE_POWERON = 4'b1000;
endpackage

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             csLd,
  input  logic             sdi,
  input  logic [CMD_W-1:0] cmdField,
  output strobe_t          strobe,
  output logic             sdiSync
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sckPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] sdiPipe;
  logic sckLast, csLast;
  logic sckRise, csRise;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckPipe[g] <= 1'b0;
          csPipe[g]  <= 1'b1;
          sdiPipe[g] <= 1'b0;
        end else begin
          sckPipe[g] <= sck;
          csPipe[g]  <= csLd;
          sdiPipe[g] <= sdi;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckPipe[g] <= 1'b0;
          csPipe[g]  <= 1'b1;
          sdiPipe[g] <= 1'b0;
        end else begin
          sckPipe[g] <= sckPipe[g-1];
          csPipe[g]  <= csPipe[g-1];
          sdiPipe[g] <= sdiPipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckLast <= 1'b0;
      csLast  <= 1'b1;
    end else begin
      sckLast <= sckPipe[LAST];
      csLast  <= csPipe[LAST];
    end
  end

  assign sckRise = sckPipe[LAST] & ~sckLast;
  assign csRise  = csPipe[LAST] & ~csLast;
  assign sdiSync = sdiPipe[LAST];

  always_comb begin
    strobe = '0;
    strobe.shiftEn = sckRise & ~csPipe[LAST];
    if (csRise) begin
      if (cmdField >= CMD_RANGE_LO && cmdField <= CMD_RANGE_HI) begin
        strobe.loadMode  = 1'b1;
        strobe.loadInput = 1'b1;
      end else if (cmdField == CMD_LOAD_UPD) begin
        strobe.loadInput = 1'b1;
        strobe.updateDac = 1'b1;
      end else if (cmdField == CMD_LOAD) begin
        strobe.loadInput = 1'b1;
      end else if (cmdField == CMD_UPDATE) begin
        strobe.updateDac = 1'b1;
      end
    end
  end

  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |-> !(strobe.loadInput || strobe.loadMode || strobe.updateDac)); // R2
  AST_EXEC_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadInput || strobe.updateDac) |-> !$past(strobe.loadInput || strobe.updateDac)); // R3
endmodule

// File: rtl/dac_serial_dp.sv
module dac_serial_dp
  import dac_serial_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrN,
  input  strobe_t          strobe,
  input  logic             sdiSync,
  output logic [CMD_W-1:0] cmdField,
  output logic             sdo,
  output logic [RES-1:0]   dacCode,
  output logic [CMD_W-1:0] rangeMode
);
  localparam int DATA_MSB = WORD_W - 1;

  logic [CHAIN_W-1:0] chainReg;
  logic [RES-1:0]     inReg;
  logic [RES-1:0]     frameData;

  assign cmdField  = chainReg[CMD_MSB -: CMD_W];
  assign frameData = chainReg[DATA_MSB -: RES];
  assign sdo       = chainReg[CHAIN_W-1];

  always_ff @(posedge clk or negedge rstN or negedge clrN) begin
    if (!rstN || !clrN) begin
      chainReg <= '0;
      inReg    <= '0;
      dacCode  <= '0;
    end else begin
      if (strobe.shiftEn)   chainReg <= {chainReg[CHAIN_W-2:0], sdiSync};
      if (strobe.loadInput) inReg <= frameData;
      if (strobe.updateDac) dacCode <= strobe.loadInput ? frameData : inReg;
    end
  end

  always_ff @(posedge clk or negedge rstN or negedge clrN) begin
    if (!rstN)                rangeMode <= MODE_POWERON;
    else if (!clrN)           rangeMode <= '0;
    else if (strobe.loadMode) rangeMode <= cmdField;
  end

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !$past(strobe.shiftEn) |-> $stable(chainReg)); // R2
  AST_DAC_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !$past(strobe.updateDac) |-> $stable(dacCode)); // R6
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    (rangeMode == 4'b0000) || (rangeMode >= CMD_RANGE_LO && rangeMode <= CMD_RANGE_HI)); // R4
  AST_LOAD_UPD_SAME: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    (strobe.updateDac && strobe.loadInput) |=> (dacCode == inReg)); // R5
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_serial_pkg::*;
#(
  parameter int RES         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrN,
  input  logic             sck,
  input  logic             csLd,
  input  logic             sdi,
  output logic             sdo,
  output logic [RES-1:0]   dacCode,
  output logic [CMD_W-1:0] rangeMode
);
  strobe_t          strobe;
  logic             sdiSync;
  logic [CMD_W-1:0] cmdField;

  dac_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csLd(csLd), .sdi(sdi),
    .cmdField(cmdField), .strobe(strobe), .sdiSync(sdiSync)
  );

  dac_serial_dp #(.RES(RES)) u_dp (
    .clk(clk), .rstN(rstN), .clrN(clrN), .strobe(strobe), .sdiSync(sdiSync),
    .cmdField(cmdField), .sdo(sdo), .dacCode(dacCode), .rangeMode(rangeMode)
  );
endmodule

// File: tb/dac_serial_front_tb.sv
module dac_serial_front_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, clrN = 1'b1, sck = 1'b0, csLd = 1'b1, sdi = 1'b0;
  logic sdo, sdo12;
  logic [15:0] dacCode;
  logic [11:0] dac12;
  logic [3:0] rangeMode, range12;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] expSr;
  logic [15:0] expIn, expDac;
  logic [3:0]  expMode;

  always #5 clk = ~clk;

  dac_serial_front #(.RES(16)) u_dut (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sck(sck), .csLd(csLd), .sdi(sdi),
    .sdo(sdo), .dacCode(dacCode), .rangeMode(rangeMode));

  dac_serial_front #(.RES(12)) u_dut12 (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sck(sck), .csLd(csLd), .sdi(sdi),
    .sdo(sdo12), .dacCode(dac12), .rangeMode(range12));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] c);
    if (c >= 4'b1000 && c <= 4'b1101) return "R4";
    if (c == 4'b0011) return "R5";
    if (c == 4'b0010 || c == 4'b0001) return "R6";
    return "R7";
  endfunction

  task automatic execModel();
    logic [3:0] c;
    logic [15:0] d;
    c = expSr[23:20];
    d = expSr[15:0];
    if (c >= 4'b1000 && c <= 4'b1101) begin expMode = c; expIn = d; end
    else if (c == 4'b0011) begin expIn = d; expDac = d; end
    else if (c == 4'b0010) expIn = d;
    else if (c == 4'b0001) expDac = expIn;
  endtask

  task automatic checkOutputs(input string req);
    check(req, "dacCode", 32'(dacCode), 32'(expDac));
    check(req, "rangeMode", 32'(rangeMode), 32'(expMode));
    check("R10", "dacCode RES=12", 32'(dac12), 32'(expDac[15:4]));
    check("R8", "sdo after frame", 32'(sdo), 32'(expSr[31]));
  endtask

  task automatic sendFrame(input int nbits, input logic [31:0] word, input string req);
    @(negedge clk) csLd = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = word[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      expSr = {expSr[30:0], word[i]};
      repeat (4) @(negedge clk);
      sck = 1'b0;
      if (nbits == 32) check("R8", "sdo mid-frame", 32'(sdo), 32'(expSr[31]));
    end
    repeat (4) @(negedge clk);
    csLd = 1'b1;
    repeat (8) @(negedge clk);
    execModel();
    checkOutputs(req);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] pre, input logic [3:0] c,
                                     input logic [3:0] dc, input logic [15:0] d);
    return {pre, c, dc, d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    expSr = '0; expIn = '0; expDac = '0; expMode = 4'b1000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 power-on values
    check("R1", "dacCode", 32'(dacCode), 32'h0);
    check("R1", "rangeMode", 32'(rangeMode), 32'h8);
    check("R1", "sdo", 32'(sdo), 32'h0);
    check("R1", "dacCode RES=12", 32'(dac12), 32'h0);

    // R3: same content as 24-bit and 32-bit frames
    sendFrame(24, mk(8'h00, 4'b0011, 4'hF, 16'h1234), "R3");
    check("R3", "24-bit load+update", 32'(dacCode), 32'h1234);
    sendFrame(32, mk(8'hA5, 4'b0011, 4'h6, 16'hBEEF), "R3");
    check("R3", "32-bit load+update", 32'(dacCode), 32'hBEEF);
    check("R10", "truncated ABCD-style", 32'(dac12), 32'hBEE);

    // R4 range set keeps dac
    sendFrame(24, mk(8'h00, 4'b1010, 4'h0, 16'h0F0F), "R4");
    check("R4", "dac held on range set", 32'(dacCode), 32'hBEEF);
    // R6 load then update
    sendFrame(24, mk(8'h00, 4'b0010, 4'h0, 16'hABCD), "R6");
    check("R6", "load only keeps dac", 32'(dacCode), 32'hBEEF);
    sendFrame(24, mk(8'h00, 4'b0001, 4'h0, 16'h5555), "R6");
    check("R6", "update copies input", 32'(dacCode), 32'hABCD);
    check("R10", "RES=12 ABCD", 32'(dac12), 32'hABC);
    // R7 no-op must not touch input register
    sendFrame(24, mk(8'h00, 4'b0010, 4'h0, 16'h1111), "R6");
    sendFrame(24, mk(8'h00, 4'b1111, 4'h0, 16'h2222), "R7");
    sendFrame(24, mk(8'h00, 4'b0001, 4'h0, 16'h3333), "R7");
    check("R7", "no-op left input reg", 32'(dacCode), 32'h1111);

    // R2 sck with csLd high does nothing
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) sdi = ~expSr[31];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R2", "sdo with csLd high", 32'(sdo), 32'(expSr[31]));
    sendFrame(24, mk(8'h00, 4'b0000, 4'h0, 16'h0000), "R2");

    // R9 clear then update
    sendFrame(24, mk(8'h00, 4'b1011, 4'h0, 16'h7777), "R4");
    sendFrame(24, mk(8'h00, 4'b0011, 4'h0, 16'h9999), "R5");
    @(negedge clk) clrN = 1'b0;
    repeat (3) @(negedge clk);
    clrN = 1'b1;
    expSr = '0; expIn = '0; expDac = '0; expMode = 4'b0000;
    repeat (2) @(negedge clk);
    check("R9", "dacCode after clear", 32'(dacCode), 32'h0);
    check("R9", "rangeMode after clear", 32'(rangeMode), 32'h0);
    check("R9", "sdo after clear", 32'(sdo), 32'h0);
    sendFrame(24, mk(8'h00, 4'b0001, 4'h0, 16'hFFFF), "R9");
    check("R9", "update after clear", 32'(dacCode), 32'h0);

    // random frames
    for (int n = 0; n < 60; n++) begin
      logic [3:0] c;
      logic [31:0] w;
      c = 4'($urandom_range(0, 15));
      w = mk(8'($urandom), c, 4'($urandom), 16'($urandom));
      if ($urandom_range(0, 1) == 1) sendFrame(32, w, reqOf(c));
      else sendFrame(24, w, reqOf(c));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule